// File: doc/BRIEF.md
# Asynchronous static RAM cycle sequencer

This block sits between a simple single-word host port and an asynchronous static RAM. Each accepted request becomes one complete bus cycle on the memory side. The block drives the address and an active-low chip select. It drives an active-low write strobe and a data output with its own output enable, and it takes a separate data input. A pad ring or a bench joins these into one shared bidirectional bus. Every interval of the memory cycle is a parameter counted in clock cycles: address lead, write pulse width, write data lead, write data hold, address hold, read access from address, select-to-data and bus release. Any parameter given below 1 is treated as 1. The write data lead is capped at the pulse width.

The host port is valid/ready. A request (`req_write`, `req_addr`, `req_wdata`) is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no cycle is in progress. The host must hold its fields stable while it waits. The block copies the fields at acceptance and ignores them afterwards. The completion side has no back-pressure: `rsp_valid` is a one-cycle pulse, and for reads `rsp_rdata` carries the word sampled from the memory. A read cycle does not end until the memory's outputs have had time to release the bus. Only then can a following cycle drive the bus or select the memory again.

Derived lengths:
- Setup length S is SETUP_CYC.
- Read strobe length LR is the largest of SEL_TO_DATA_CYC, ACCESS_CYC minus S, and 1.
- Write tail HW is the larger of WDATA_HOLD_CYC and ADDR_HOLD_CYC.
- Read tail HR is the larger of FLOAT_CYC and ADDR_HOLD_CYC.

Cycle k = 0 is the first clock cycle after the accepting edge.

Top module: `sram_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, `sram_cs_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: `req_ready` is 0 from cycle 0 up to the end of the cycle's tail. While it is 0, `req_valid` and the request fields have no effect on the memory side, and no new cycle follows once they are withdrawn.
- R3: In a read, for k < S the address is driven, `sram_we_n`=1 and `sram_cs_n`=1.
- R4: In a read, `sram_cs_n`=0 with `sram_we_n`=1 for the LR cycles starting at k = S. `sram_dq_i` is sampled at the edge that ends the last of those cycles. `rsp_valid`=1 only at k = S+LR.
- R5: After a read strobe, `sram_cs_n` stays 1 and `sram_dq_oe` stays 0 for HR cycles. The data output enable is never high during a read.
- R6: In a write, for k < S only the address is driven with both strobes high. Then `sram_cs_n` and `sram_we_n` are 0 together for PULSE_CYC cycles.
- R7: In a write, `sram_dq_oe`=1 carrying the request data only during two spans: the last WDATA_LEAD_CYC cycles of the pulse, and the first WDATA_HOLD_CYC cycles after it. At all other times `sram_dq_oe`=0.
- R8: After a write pulse both strobes stay 1 for HW cycles before the block is ready again. `rsp_valid`=1 only at k = S+PULSE_CYC.
- R9: `sram_addr` equals the accepted address in every cycle from k = 0 to the end of the tail.
- R10: `req_ready` returns to 1 at k = S+PULSE_CYC+HW for writes and at k = S+LR+HR for reads. A request held valid is accepted in that cycle.
- R11: A read returns on `rsp_rdata` the word last written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last word read |
| sram_addr | output | ADDR_W | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | DATA_W | Data toward memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | DATA_W | Data from memory |

## Verification
A write sweep over every address is followed by a read sweep. Both run back to back with the next request already valid. This separates correct acceptance timing and address capture from a design that leaks the pending request onto the bus. The memory model returns a junk word until both the address age and the select age reach their minimums. A strobe cut short therefore shows up as wrong read data, and mismatched write/read pairs expose misplaced data windows. Alternating write and read to one address with all-zero, all-one and mixed words separates the write path from the read path. A valid pulse injected mid-cycle and then dropped checks that requests are ignored while busy.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_TAIL   = 2'd3
  } phase_t;

  function automatic int at_least(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  function automatic int at_most(input int v, input int m);
    return (v > m) ? m : v;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  assign last = run && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || last)
      cnt <= '0;
    else
      cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CNT_W         = 4,
  parameter int SETUP_LEN     = 1,
  parameter int WR_STROBE_LEN = 2,
  parameter int RD_STROBE_LEN = 2,
  parameter int WR_TAIL_LEN   = 1,
  parameter int RD_TAIL_LEN   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             accept,
  output phase_t           phase,
  output logic             is_wr,
  output logic             run,
  output logic [CNT_W-1:0] len,
  input  logic             last,
  output logic             strobe_end
);

  phase_t phase_q, phase_d;
  logic   wr_q;

  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign phase      = phase_q;
  assign is_wr      = wr_q;
  assign run        = (phase_q != PH_IDLE);
  assign strobe_end = (phase_q == PH_STROBE) && last;

  always_comb begin
    unique case (phase_q)
      PH_SETUP:  len = CNT_W'(SETUP_LEN);
      PH_STROBE: len = wr_q ? CNT_W'(WR_STROBE_LEN) : CNT_W'(RD_STROBE_LEN);
      PH_TAIL:   len = wr_q ? CNT_W'(WR_TAIL_LEN) : CNT_W'(RD_TAIL_LEN);
      default:   len = CNT_W'(1);
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_SETUP;
      PH_SETUP:  if (last) phase_d = PH_STROBE;
      PH_STROBE: if (last) phase_d = PH_TAIL;
      PH_TAIL:   if (last) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) wr_q <= req_write;
    end
  end

  // R2: once a request is taken the block is busy in the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R10: the final tail cycle hands straight back to ready
  a_r10_ready_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAIL && last) |=> req_ready);

endmodule

// File: rtl/sram_seq_bus.sv
module sram_seq_bus
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int PULSE_LEN = 2,
  parameter int LEAD_LEN  = 1,
  parameter int DHOLD_LEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase,
  input  logic              is_wr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              strobe_end,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int LEAD_START = PULSE_LEN - LEAD_LEN;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;
  logic              in_strobe, lead_win, hold_win;

  assign in_strobe = (phase == PH_STROBE);
  assign lead_win  = in_strobe && (cnt >= CNT_W'(LEAD_START));
  assign hold_win  = (phase == PH_TAIL) && (cnt < CNT_W'(DHOLD_LEN));

  assign sram_addr  = addr_q;
  assign sram_cs_n  = !in_strobe;
  assign sram_we_n  = !(in_strobe && is_wr);
  assign sram_dq_o  = wdata_q;
  assign sram_dq_oe = is_wr && (lead_win || hold_win);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (strobe_end && !is_wr) rdata_q <= sram_dq_i;
      rsp_q <= strobe_end;
    end
  end

  // R6: the write strobe never appears without the chip select
  a_r6_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n);

  // R5: never drive data while the memory may be driving it
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !(!sram_cs_n && sram_we_n));

  // R9: address does not move between consecutive busy cycles
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase != PH_IDLE)) |-> $stable(sram_addr));

  // R4: completion is a single-cycle pulse
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 16,
  parameter int SETUP_CYC       = 1,
  parameter int PULSE_CYC       = 2,
  parameter int WDATA_LEAD_CYC  = 1,
  parameter int WDATA_HOLD_CYC  = 1,
  parameter int ADDR_HOLD_CYC   = 1,
  parameter int ACCESS_CYC      = 3,
  parameter int SEL_TO_DATA_CYC = 2,
  parameter int FLOAT_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int S_LEN   = at_least(SETUP_CYC, 1);
  localparam int W_LEN   = at_least(PULSE_CYC, 1);
  localparam int LEAD    = at_most(at_least(WDATA_LEAD_CYC, 1), W_LEN);
  localparam int DHOLD   = at_least(WDATA_HOLD_CYC, 1);
  localparam int AHOLD   = at_least(ADDR_HOLD_CYC, 1);
  localparam int ACC     = at_least(ACCESS_CYC, 1);
  localparam int CSD     = at_least(SEL_TO_DATA_CYC, 1);
  localparam int FLT     = at_least(FLOAT_CYC, 1);
  localparam int R_LEN   = at_least(at_least(CSD, ACC - S_LEN), 1);
  localparam int WT_LEN  = at_least(DHOLD, AHOLD);
  localparam int RT_LEN  = at_least(FLT, AHOLD);
  localparam int MAX_LEN = at_least(at_least(at_least(S_LEN, W_LEN), at_least(R_LEN, WT_LEN)), RT_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;

  phase_t           phase;
  logic             accept, is_wr, run, last, strobe_end;
  logic [CNT_W-1:0] len, cnt;

  sram_seq_ctrl #(
    .CNT_W(CNT_W), .SETUP_LEN(S_LEN), .WR_STROBE_LEN(W_LEN),
    .RD_STROBE_LEN(R_LEN), .WR_TAIL_LEN(WT_LEN), .RD_TAIL_LEN(RT_LEN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .phase(phase), .is_wr(is_wr),
    .run(run), .len(len), .last(last), .strobe_end(strobe_end)
  );

  sram_seq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .len(len), .cnt(cnt), .last(last)
  );

  sram_seq_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PULSE_LEN(W_LEN), .LEAD_LEN(LEAD), .DHOLD_LEN(DHOLD)
  ) bus_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .phase(phase), .is_wr(is_wr), .cnt(cnt),
    .strobe_end(strobe_end), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

endmodule

// File: tb/sram_cycle_seq_tb.sv
module sram_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int TAS  = 2;
  localparam int TW   = 4;
  localparam int TDS  = 2;
  localparam int TDH  = 1;
  localparam int TAH  = 2;
  localparam int TACC = 5;
  localparam int TCO  = 2;
  localparam int TF   = 4;
  localparam int LR   = (TCO > TACC - TAS) ? TCO : TACC - TAS;
  localparam int HW   = (TDH > TAH) ? TDH : TAH;
  localparam int HR   = (TF > TAH) ? TF : TAH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] exp_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(TAS), .PULSE_CYC(TW),
    .WDATA_LEAD_CYC(TDS), .WDATA_HOLD_CYC(TDH), .ADDR_HOLD_CYC(TAH),
    .ACCESS_CYC(TACC), .SEL_TO_DATA_CYC(TCO), .FLOAT_CYC(TF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // behavioural memory with access-age modelling
  logic [DW-1:0] ram [16];
  logic [AW-1:0] prev_addr = '0;
  int acnt = 0, ccnt = 0;
  logic [DW-1:0] wbuf = '0;
  logic [AW-1:0] waddr = '0;
  logic wact = 1'b0;
  int a_el, c_el;
  logic [DW-1:0] bus_val;

  always_comb begin
    a_el = (sram_addr == prev_addr) ? acnt + 1 : 1;
    c_el = ccnt + 1;
    bus_val = sram_dq_oe ? sram_dq_o : 8'hEE;
    if (!sram_cs_n && sram_we_n)
      sram_dq_i = (a_el >= TACC && c_el >= TCO) ? ram[sram_addr] : 8'hEE;
    else
      sram_dq_i = 8'h00;
  end

  always @(posedge clk) begin
    acnt <= (sram_addr == prev_addr) ? ((acnt < 1000) ? acnt + 1 : acnt) : 1;
    prev_addr <= sram_addr;
    ccnt <= !sram_cs_n ? ccnt + 1 : 0;
    if (!sram_cs_n && !sram_we_n) begin
      wbuf <= bus_val; waddr <= sram_addr; wact <= 1'b1;
    end else if (wact) begin
      ram[waddr] <= wbuf; wact <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(sram_cs_n == 1'b1, "R2 cs idle", int'(sram_cs_n), 1);
      chk(req_ready == 1'b1, "R2 ready idle", int'(req_ready), 1);
      chk(sram_dq_oe == 1'b0, "R7 oe idle", int'(sram_dq_oe), 0);
    end
  endtask

  // called at a negedge while idle; returns at the negedge where ready is back
  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit nv, input bit nw, input logic [AW-1:0] na,
                       input logic [DW-1:0] nd, input bit glitch);
    int len;
    bit str, oe_e, rv;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = nv; req_write = nw; req_addr = na; req_wdata = nd;
    len = w ? TAS + TW + HW : TAS + LR + HR;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (glitch && k == 1) begin
        req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~d;
      end
      if (glitch && k == 2) req_valid = 1'b0;
      if (w) begin
        str  = (k >= TAS) && (k < TAS + TW);
        oe_e = ((k >= TAS + TW - TDS) && (k < TAS + TW)) ||
               ((k >= TAS + TW) && (k < TAS + TW + TDH));
        rv   = (k == TAS + TW);
        chk(sram_cs_n == !str, (k < TAS + TW) ? "R6 cs" : "R8 cs", int'(sram_cs_n), int'(!str));
        chk(sram_we_n == !str, (k < TAS + TW) ? "R6 we" : "R8 we", int'(sram_we_n), int'(!str));
        chk(rsp_valid == rv, "R8 done", int'(rsp_valid), int'(rv));
        if (oe_e) chk(sram_dq_o == d, "R7 wdata", int'(sram_dq_o), int'(d));
      end else begin
        str  = (k >= TAS) && (k < TAS + LR);
        oe_e = 1'b0;
        rv   = (k == TAS + LR);
        chk(sram_cs_n == !str, (k < TAS) ? "R3 cs" : (str ? "R4 cs" : "R5 cs"),
            int'(sram_cs_n), int'(!str));
        chk(sram_we_n == 1'b1, (k < TAS) ? "R3 we" : "R4 we", int'(sram_we_n), 1);
        chk(rsp_valid == rv, "R4 done", int'(rsp_valid), int'(rv));
        if (rv) chk(rsp_rdata == exp_mem[a], "R11 rdata", int'(rsp_rdata), int'(exp_mem[a]));
      end
      chk(sram_dq_oe == oe_e, w ? "R7 oe" : "R5 oe", int'(sram_dq_oe), int'(oe_e));
      chk(sram_addr == a, "R9 addr", int'(sram_addr), int'(a));
      chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
    if (w) exp_mem[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] dv;
    for (int i = 0; i < 16; i++) begin exp_mem[i] = '0; ram[i] = '0; end
    repeat (2) @(negedge clk);
    chk(sram_cs_n == 1'b1, "R1 cs", int'(sram_cs_n), 1);
    chk(sram_we_n == 1'b1, "R1 we", int'(sram_we_n), 1);
    chk(sram_dq_oe == 1'b0, "R1 oe", int'(sram_dq_oe), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_cs_n == 1'b1 && req_ready == 1'b1, "R1 after release",
        int'({sram_cs_n, req_ready}), 3);

    // write sweep, back to back, next request already pending
    for (int i = 0; i < 16; i++) begin
      dv = DW'((i * 37 + 5) & 8'hFF);
      do_op(1'b1, AW'(i), dv, i < 15, 1'b1, AW'(i + 1),
            DW'(((i + 1) * 37 + 5) & 8'hFF), 1'b0);
    end
    // read sweep, back to back
    for (int i = 0; i < 16; i++)
      do_op(1'b0, AW'(i), 8'h00, i < 15, 1'b0, AW'(i + 1), 8'h00, 1'b0);
    idle_chk(2);

    // alternating write/read on one address with varied words
    for (int i = 0; i < 8; i++) begin
      case (i)
        0: dv = 8'h00;
        1: dv = 8'hFF;
        2: dv = 8'hAA;
        3: dv = 8'h55;
        default: dv = DW'((i * 73 + 11) & 8'hFF);
      endcase
      do_op(1'b1, AW'(i * 5), dv, 1'b1, 1'b0, AW'(i * 5), 8'h00, 1'b0);
      do_op(1'b0, AW'(i * 5), 8'h00, 1'b0, 1'b0, '0, '0, i[0]);
      idle_chk(i[0] ? 3 : 1);
    end

    // request pulsed and withdrawn during a write
    do_op(1'b1, 4'd9, 8'h3C, 1'b0, 1'b0, '0, '0, 1'b1);
    idle_chk(3);
    do_op(1'b0, 4'd6, 8'h00, 1'b0, 1'b0, '0, '0, 1'b0);
    do_op(1'b0, 4'd9, 8'h00, 1'b0, 1'b0, '0, '0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule